// File: doc/BRIEF.md
# Instruction Wait/Ready/Issue Scheduler

This block is the issue queue between dispatch and the execution pipes. Each dispatched instruction is identified by a tag and takes one of eight entries. It is placed as waiting or ready, depending on whether its producer operand and its memory ordering are already satisfied. It is promoted once both are satisfied, and then it competes for the single issue slot. Once issued, it counts down its latency in the executing state and leaves through the writeback port.

Producers wake consumers by broadcasting their own tag on the operand wakeup port. Each entry records the one producer tag it depends on. Memory ordering is released per entry, by the entry's own tag on the memory wakeup port. Selection ranks ready entries by an age counter. Entries with more than one known consumer get a fixed bonus, so that work that unblocks several others goes first. An instruction that must not wait, such as a zero-latency operation or one behind an in-order hazard, goes straight to the issue port in its dispatch cycle.

Top module: `sched_wrq`

## Requirements
- R1: After reset, issue_valid_o and wb_valid_o are low and stall_o reads 0 while no queue-full or group-stall input is set.
- R2: A dispatch with disp_opnd_rdy_i and disp_mem_rdy_i both set makes the entry ready, and it is issued in the next cycle if it wins selection. If either flag is clear, the entry waits and is not issued.
- R3: A waiting entry becomes ready at the clock edge where both conditions hold: a wakeup with its producer tag has arrived on opw, and one with its own tag has arrived on mw. Each condition is remembered once seen. The promoted entry is offered to selection one cycle after that edge, and no earlier.
- R4: Among ready entries of equal user bonus, the one dispatched earliest is issued first.
- R5: An entry's score is its age plus 2 when disp_users_i was above 1. The highest score issues, and on equal scores the lower entry index (lower free slot at dispatch) wins.
- R6: At most one tag is issued per cycle. An issued entry enters the executing state and is never issued again.
- R7: An entry issued with latency L raises wb_valid_o with its tag L+1 cycles after its issue cycle. When several are due at once, one writes back per cycle, lowest entry first.
- R8: stall_o encodes 0 available, 1 load queue full (disp_is_load_i and lq_full_i), 2 store queue full (disp_is_store_i and sq_full_i), 3 no free entry, 4 group stall (grp_stall_i). The lowest nonzero code that applies is reported.
- R9: A dispatch presented while stall_o is nonzero is ignored: no entry is taken and nothing is issued for it.
- R10: An accepted dispatch with disp_imm_i set shows its tag on the issue port in the same cycle, regardless of operand state, and selection of other entries is deferred by that cycle.
- R11: With all eight entries occupied stall_o reads 3. An entry freed by writeback can be allocated again afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Dispatch request |
| disp_tag_i | input | 4 | Tag of the dispatched instruction |
| disp_dep_i | input | 4 | Producer tag this instruction waits on |
| disp_opnd_rdy_i | input | 1 | Operand already available |
| disp_mem_rdy_i | input | 1 | Memory ordering already satisfied |
| disp_users_i | input | 3 | Number of known consumers |
| disp_lat_i | input | 4 | Execution latency in cycles |
| disp_imm_i | input | 1 | Must issue in the dispatch cycle |
| disp_is_load_i | input | 1 | Instruction needs a load queue slot |
| disp_is_store_i | input | 1 | Instruction needs a store queue slot |
| lq_full_i | input | 1 | Load queue has no room |
| sq_full_i | input | 1 | Store queue has no room |
| grp_stall_i | input | 1 | Dispatch group must stall |
| opw_valid_i | input | 1 | Operand wakeup broadcast valid |
| opw_tag_i | input | 4 | Tag of the producer that completed |
| mw_valid_i | input | 1 | Memory ordering release valid |
| mw_tag_i | input | 4 | Tag whose memory ordering is released |
| stall_o | output | 3 | Dispatch status code |
| issue_valid_o | output | 1 | An instruction issues this cycle |
| issue_tag_o | output | 4 | Tag being issued |
| wb_valid_o | output | 1 | An instruction writes back this cycle |
| wb_tag_o | output | 4 | Tag writing back |

## Verification
On every cycle the assertions check several properties. Refused dispatches never grow occupancy. A full pool reports code 3. Ready entries never fall back to waiting, and at most one entry is issued. Selection only issues when something is ready, writeback only happens while something executes, and immediate dispatches reach the issue port at once. Only the bench scenarios can show the orderings: age before youth, the user bonus and its tie rule, and late-issued short-latency work writing back first. The exact promotion and latency cycle counts, and reuse of freed entries, also need those scenarios.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    ST_FREE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_READY = 2'd2,
    ST_EXEC  = 2'd3
  } ent_st_e;

  typedef enum logic [2:0] {
    SC_OK        = 3'd0,
    SC_LQ_FULL   = 3'd1,
    SC_SQ_FULL   = 3'd2,
    SC_BUF_FULL  = 3'd3,
    SC_GRP_STALL = 3'd4
  } stall_e;
endpackage

// File: rtl/sched_penc.sv
module sched_penc #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/sched_pick.sv
module sched_pick #(
  parameter int N       = 8,
  parameter int SCORE_W = 5,
  parameter int IDX_W   = $clog2(N)
) (
  input  logic [N-1:0]              ready_i,
  input  logic [N-1:0][SCORE_W-1:0] score_i,
  output logic                      valid_o,
  output logic [IDX_W-1:0]          idx_o
);
  logic [SCORE_W-1:0] best;

  // strict compare keeps the lowest index on equal scores
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    best    = '0;
    for (int i = 0; i < N; i++) begin
      if (ready_i[i] && (!valid_o || score_i[i] > best)) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
        best    = score_i[i];
      end
    end
  end
endmodule

// File: rtl/sched_entry.sv
module sched_entry
  import sched_pkg::*;
#(
  parameter int TAG_W = 4,
  parameter int AGE_W = 4,
  parameter int USR_W = 3,
  parameter int LAT_W = 4,
  parameter int BOOST = 2,
  localparam int SCORE_W = AGE_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               alloc_i,
  input  logic [TAG_W-1:0]   alloc_tag_i,
  input  logic [TAG_W-1:0]   alloc_dep_i,
  input  logic [USR_W-1:0]   alloc_usr_i,
  input  logic [LAT_W-1:0]   alloc_lat_i,
  input  logic               alloc_opnd_i,
  input  logic               alloc_mem_i,
  input  logic               alloc_imm_i,
  input  logic               opw_valid_i,
  input  logic [TAG_W-1:0]   opw_tag_i,
  input  logic               mw_valid_i,
  input  logic [TAG_W-1:0]   mw_tag_i,
  input  logic               issue_i,
  input  logic               retire_i,
  output ent_st_e            state_o,
  output logic [TAG_W-1:0]   tag_o,
  output logic [SCORE_W-1:0] score_o,
  output logic               done_o
);
  localparam logic [SCORE_W-1:0] BOOST_V = SCORE_W'(BOOST);

  ent_st_e            st_q;
  logic [TAG_W-1:0]   tag_q, dep_q;
  logic [USR_W-1:0]   usr_q;
  logic [LAT_W-1:0]   cnt_q;
  logic [AGE_W-1:0]   age_q;
  logic               opnd_q, mem_q;
  logic               opnd_hit, mem_hit, opnd_ok, mem_ok;

  assign opnd_hit = opw_valid_i && (opw_tag_i == dep_q);
  assign mem_hit  = mw_valid_i && (mw_tag_i == tag_q);
  assign opnd_ok  = opnd_q | opnd_hit;
  assign mem_ok   = mem_q | mem_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_FREE;
      tag_q  <= '0;
      dep_q  <= '0;
      usr_q  <= '0;
      cnt_q  <= '0;
      age_q  <= '0;
      opnd_q <= 1'b0;
      mem_q  <= 1'b0;
    end else if (alloc_i) begin
      tag_q  <= alloc_tag_i;
      dep_q  <= alloc_dep_i;
      usr_q  <= alloc_usr_i;
      cnt_q  <= alloc_lat_i;
      age_q  <= '0;
      opnd_q <= alloc_opnd_i;
      mem_q  <= alloc_mem_i;
      if (alloc_imm_i)                      st_q <= ST_EXEC;
      else if (alloc_opnd_i && alloc_mem_i) st_q <= ST_READY;
      else                                  st_q <= ST_WAIT;
    end else begin
      unique case (st_q)
        ST_WAIT: begin
          opnd_q <= opnd_ok;
          mem_q  <= mem_ok;
          if (age_q != '1) age_q <= age_q + 1'b1;
          if (opnd_ok && mem_ok) st_q <= ST_READY;
        end
        ST_READY: begin
          if (age_q != '1) age_q <= age_q + 1'b1;
          if (issue_i) st_q <= ST_EXEC;
        end
        ST_EXEC: begin
          if (retire_i)            st_q  <= ST_FREE;
          else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign state_o = st_q;
  assign tag_o   = tag_q;
  assign score_o = {1'b0, age_q} + ((usr_q > USR_W'(1)) ? BOOST_V : '0);
  assign done_o  = (st_q == ST_EXEC) && (cnt_q == '0);
endmodule

// File: rtl/sched_wrq.sv
module sched_wrq
  import sched_pkg::*;
#(
  parameter int N_ENT = 8,
  parameter int TAG_W = 4,
  parameter int AGE_W = 4,
  parameter int USR_W = 3,
  parameter int LAT_W = 4,
  parameter int BOOST = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             disp_valid_i,
  input  logic [TAG_W-1:0] disp_tag_i,
  input  logic [TAG_W-1:0] disp_dep_i,
  input  logic             disp_opnd_rdy_i,
  input  logic             disp_mem_rdy_i,
  input  logic [USR_W-1:0] disp_users_i,
  input  logic [LAT_W-1:0] disp_lat_i,
  input  logic             disp_imm_i,
  input  logic             disp_is_load_i,
  input  logic             disp_is_store_i,
  input  logic             lq_full_i,
  input  logic             sq_full_i,
  input  logic             grp_stall_i,
  input  logic             opw_valid_i,
  input  logic [TAG_W-1:0] opw_tag_i,
  input  logic             mw_valid_i,
  input  logic [TAG_W-1:0] mw_tag_i,
  output logic [2:0]       stall_o,
  output logic             issue_valid_o,
  output logic [TAG_W-1:0] issue_tag_o,
  output logic             wb_valid_o,
  output logic [TAG_W-1:0] wb_tag_o
);
  localparam int IDX_W   = $clog2(N_ENT);
  localparam int SCORE_W = AGE_W + 1;

  ent_st_e                        st_arr [N_ENT];
  logic [N_ENT-1:0][TAG_W-1:0]    tag_arr;
  logic [N_ENT-1:0][SCORE_W-1:0]  score_arr;
  logic [N_ENT-1:0]               busy_v, wait_v, ready_v, exec_v, done_v;
  logic [N_ENT-1:0]               alloc_v, issue_v, retire_v;

  logic             free_ok, pick_ok, disp_go, imm_go;
  logic [IDX_W-1:0] free_idx, pick_idx, ret_idx;
  stall_e           stall_c;

  sched_penc #(.N(N_ENT), .IDX_W(IDX_W)) u_free (
    .req_i  (~busy_v),
    .valid_o(free_ok),
    .idx_o  (free_idx)
  );

  always_comb begin
    if (disp_is_load_i && lq_full_i)       stall_c = SC_LQ_FULL;
    else if (disp_is_store_i && sq_full_i) stall_c = SC_SQ_FULL;
    else if (!free_ok)                     stall_c = SC_BUF_FULL;
    else if (grp_stall_i)                  stall_c = SC_GRP_STALL;
    else                                   stall_c = SC_OK;
  end

  assign stall_o = stall_c;
  assign disp_go = disp_valid_i && (stall_c == SC_OK);
  assign imm_go  = disp_go && disp_imm_i;

  sched_pick #(.N(N_ENT), .SCORE_W(SCORE_W), .IDX_W(IDX_W)) u_pick (
    .ready_i(ready_v),
    .score_i(score_arr),
    .valid_o(pick_ok),
    .idx_o  (pick_idx)
  );

  sched_penc #(.N(N_ENT), .IDX_W(IDX_W)) u_ret (
    .req_i  (done_v),
    .valid_o(wb_valid_o),
    .idx_o  (ret_idx)
  );

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    assign alloc_v[g]  = disp_go && (free_idx == IDX_W'(g));
    assign issue_v[g]  = !imm_go && pick_ok && (pick_idx == IDX_W'(g));
    assign retire_v[g] = wb_valid_o && (ret_idx == IDX_W'(g));
    assign busy_v[g]   = (st_arr[g] != ST_FREE);
    assign wait_v[g]   = (st_arr[g] == ST_WAIT);
    assign ready_v[g]  = (st_arr[g] == ST_READY);
    assign exec_v[g]   = (st_arr[g] == ST_EXEC);

    sched_entry #(
      .TAG_W(TAG_W), .AGE_W(AGE_W), .USR_W(USR_W),
      .LAT_W(LAT_W), .BOOST(BOOST)
    ) u_ent (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .alloc_i     (alloc_v[g]),
      .alloc_tag_i (disp_tag_i),
      .alloc_dep_i (disp_dep_i),
      .alloc_usr_i (disp_users_i),
      .alloc_lat_i (disp_lat_i),
      .alloc_opnd_i(disp_opnd_rdy_i),
      .alloc_mem_i (disp_mem_rdy_i),
      .alloc_imm_i (disp_imm_i),
      .opw_valid_i (opw_valid_i),
      .opw_tag_i   (opw_tag_i),
      .mw_valid_i  (mw_valid_i),
      .mw_tag_i    (mw_tag_i),
      .issue_i     (issue_v[g]),
      .retire_i    (retire_v[g]),
      .state_o     (st_arr[g]),
      .tag_o       (tag_arr[g]),
      .score_o     (score_arr[g]),
      .done_o      (done_v[g])
    );
  end

  assign issue_valid_o = imm_go || pick_ok;
  assign issue_tag_o   = imm_go ? disp_tag_i : tag_arr[pick_idx];
  assign wb_tag_o      = tag_arr[ret_idx];
endmodule

// File: rtl/sched_wrq_chk.sv
module sched_wrq_chk #(
  parameter int N_ENT = 8,
  parameter int TAG_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             disp_valid_i,
  input logic             disp_imm_i,
  input logic [TAG_W-1:0] disp_tag_i,
  input logic             disp_is_load_i,
  input logic             disp_is_store_i,
  input logic             lq_full_i,
  input logic             sq_full_i,
  input logic [2:0]       stall_o,
  input logic             issue_valid_o,
  input logic [TAG_W-1:0] issue_tag_o,
  input logic             wb_valid_o,
  input logic [N_ENT-1:0] busy_v,
  input logic [N_ENT-1:0] wait_v,
  input logic [N_ENT-1:0] ready_v,
  input logic [N_ENT-1:0] exec_v,
  input logic [N_ENT-1:0] issue_v
);
  logic imm_go;
  assign imm_go = disp_valid_i && disp_imm_i && (stall_o == 3'd0);

  AST_NO_DISP_ON_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_i && stall_o != 3'd0) |=> ($countones(busy_v) <= $past($countones(busy_v)))); // R9

  AST_FULL_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&busy_v) && !(disp_is_load_i && lq_full_i) && !(disp_is_store_i && sq_full_i))
      |-> (stall_o == 3'd3)); // R11

  AST_ONE_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(issue_v)); // R6

  AST_ISSUE_HAS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && !imm_go) |-> (|ready_v)); // R2

  AST_WB_HAS_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> (|exec_v)); // R7

  AST_IMM_NOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imm_go |-> (issue_valid_o && issue_tag_o == disp_tag_i)); // R10

  for (genvar g = 0; g < N_ENT; g++) begin : g_st
    AST_READY_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ready_v[g] |=> !wait_v[g]); // R3
  end
endmodule

bind sched_wrq sched_wrq_chk #(.N_ENT(N_ENT), .TAG_W(TAG_W)) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .disp_valid_i   (disp_valid_i),
  .disp_imm_i     (disp_imm_i),
  .disp_tag_i     (disp_tag_i),
  .disp_is_load_i (disp_is_load_i),
  .disp_is_store_i(disp_is_store_i),
  .lq_full_i      (lq_full_i),
  .sq_full_i      (sq_full_i),
  .stall_o        (stall_o),
  .issue_valid_o  (issue_valid_o),
  .issue_tag_o    (issue_tag_o),
  .wb_valid_o     (wb_valid_o),
  .busy_v         (busy_v),
  .wait_v         (wait_v),
  .ready_v        (ready_v),
  .exec_v         (exec_v),
  .issue_v        (issue_v)
);

// File: tb/sched_wrq_tb.sv
module sched_wrq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       disp_valid = 0, disp_opnd = 0, disp_mem = 0, disp_imm = 0;
  logic       disp_ld = 0, disp_st = 0, lq_full = 0, sq_full = 0, grp = 0;
  logic [3:0] disp_tag = 0, disp_dep = 0, disp_lat = 0, opw_tag = 0, mw_tag = 0;
  logic [2:0] disp_usr = 0;
  logic       opw_valid = 0, mw_valid = 0;
  logic [2:0] stall;
  logic       iss_v, wb_v;
  logic [3:0] iss_tag, wb_tag;

  int total = 0, bad = 0, cyc = 0;
  int iq[$];  string iq_r[$];
  int wq[$];  string wq_r[$];
  int iss_at_exp[16], iss_seen[16], lat_exp[16];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sched_wrq dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .disp_valid_i(disp_valid), .disp_tag_i(disp_tag), .disp_dep_i(disp_dep),
    .disp_opnd_rdy_i(disp_opnd), .disp_mem_rdy_i(disp_mem), .disp_users_i(disp_usr),
    .disp_lat_i(disp_lat), .disp_imm_i(disp_imm), .disp_is_load_i(disp_ld),
    .disp_is_store_i(disp_st), .lq_full_i(lq_full), .sq_full_i(sq_full),
    .grp_stall_i(grp), .opw_valid_i(opw_valid), .opw_tag_i(opw_tag),
    .mw_valid_i(mw_valid), .mw_tag_i(mw_tag), .stall_o(stall),
    .issue_valid_o(iss_v), .issue_tag_o(iss_tag), .wb_valid_o(wb_v), .wb_tag_o(wb_tag)
  );

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic exp_iss(input int t, input string r);
    iq.push_back(t); iq_r.push_back(r);
  endtask

  task automatic exp_wb(input int t, input string r);
    wq.push_back(t); wq_r.push_back(r);
  endtask

  task automatic disp(input int t, input int dep, input int usr, input int lat,
                      input bit op, input bit mem, input bit imm);
    disp_valid = 1; disp_tag = 4'(t); disp_dep = 4'(dep); disp_usr = 3'(usr);
    disp_lat = 4'(lat); disp_opnd = op; disp_mem = mem; disp_imm = imm;
    step();
    disp_valid = 0; disp_imm = 0;
  endtask

  task automatic opwake(input int t);
    opw_valid = 1; opw_tag = 4'(t); step(); opw_valid = 0;
  endtask

  task automatic memwake(input int t);
    mw_valid = 1; mw_tag = 4'(t); step(); mw_valid = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && (iq.size() != 0 || wq.size() != 0); i++) step();
    repeat (3) step();
  endtask

  // monitor: compares design output against the expected queues
  always @(negedge clk) begin
    if (rst_n) begin
      if (iss_v) begin
        if (iq.size() == 0) chk(0, "R9 unexpected issue", int'(iss_tag), -1);
        else begin
          string r; int e;
          e = iq.pop_front(); r = iq_r.pop_front();
          chk(int'(iss_tag) == e, r, int'(iss_tag), e);
          iss_seen[iss_tag] = cyc;
          if (iss_at_exp[iss_tag] >= 0) begin
            chk(cyc == iss_at_exp[iss_tag], "R3 issue cycle", cyc, iss_at_exp[iss_tag]);
            iss_at_exp[iss_tag] = -1;
          end
        end
      end
      if (wb_v) begin
        if (wq.size() == 0) chk(0, "R7 unexpected writeback", int'(wb_tag), -1);
        else begin
          string r; int e;
          e = wq.pop_front(); r = wq_r.pop_front();
          chk(int'(wb_tag) == e, r, int'(wb_tag), e);
          if (lat_exp[wb_tag] >= 0) begin
            chk(cyc == iss_seen[wb_tag] + lat_exp[wb_tag] + 1, "R7 wb cycle",
                cyc, iss_seen[wb_tag] + lat_exp[wb_tag] + 1);
            lat_exp[wb_tag] = -1;
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin iss_at_exp[i] = -1; lat_exp[i] = -1; iss_seen[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(iss_v == 0, "R1 issue idle", int'(iss_v), 0);
    chk(wb_v == 0, "R1 wb idle", int'(wb_v), 0);
    chk(stall == 0, "R1 stall", int'(stall), 0);
    step();

    // R2 / R7: ready dispatch, exact issue and wb timing
    iss_at_exp[1] = cyc + 1; lat_exp[1] = 2;
    exp_iss(1, "R2 ready dispatch"); exp_wb(1, "R7 single wb");
    disp(1, 0, 1, 2, 1, 1, 0);
    drain();

    // R2 / R3: memory ordering holds an operand-ready entry
    disp(2, 0, 1, 0, 1, 0, 0);
    repeat (4) step();
    iss_at_exp[2] = cyc + 1;
    exp_iss(2, "R3 mem release"); exp_wb(2, "R7 wb");
    memwake(2);
    drain();

    // R3: both conditions required, each remembered
    disp(3, 9, 1, 0, 0, 0, 0);
    step(); step();
    opwake(9);
    repeat (3) step();
    iss_at_exp[3] = cyc + 1;
    exp_iss(3, "R3 both met"); exp_wb(3, "R7 wb");
    memwake(3);
    drain();

    // R4: oldest first
    disp(4, 10, 1, 0, 0, 1, 0);
    disp(5, 10, 1, 0, 0, 1, 0);
    disp(6, 10, 1, 0, 0, 1, 0);
    step();
    exp_iss(4, "R4 age 1st"); exp_iss(5, "R4 age 2nd"); exp_iss(6, "R4 age 3rd");
    exp_wb(4, "R7 wb"); exp_wb(5, "R7 wb"); exp_wb(6, "R7 wb");
    opwake(10);
    drain();

    // R5: user bonus beats one cycle of age
    disp(7, 11, 1, 0, 0, 1, 0);
    disp(8, 11, 3, 0, 0, 1, 0);
    exp_iss(8, "R5 boost first"); exp_iss(7, "R5 boost second");
    exp_wb(8, "R7 wb"); exp_wb(7, "R7 wb");
    opwake(11);
    drain();

    // R5: equal score, lower entry wins
    disp(9, 12, 1, 0, 0, 1, 0);
    step();
    disp(10, 12, 2, 0, 0, 1, 0);
    exp_iss(9, "R5 tie low index"); exp_iss(10, "R5 tie other");
    exp_wb(9, "R7 wb"); exp_wb(10, "R7 wb");
    opwake(12);
    drain();

    // R10: immediate dispatch overrides a pending select
    exp_iss(12, "R10 immediate"); exp_iss(11, "R10 deferred select");
    exp_wb(12, "R7 wb"); exp_wb(11, "R7 wb");
    disp(11, 0, 1, 1, 1, 1, 0);
    iss_at_exp[12] = cyc;
    disp(12, 5, 1, 0, 0, 0, 1);
    drain();

    // R7 / R6: short latency issued later writes back first
    exp_iss(13, "R6 issue"); exp_iss(14, "R6 issue");
    exp_wb(14, "R7 short first"); exp_wb(13, "R7 long later");
    lat_exp[13] = 6; lat_exp[14] = 0;
    disp(13, 0, 1, 6, 1, 1, 0);
    disp(14, 0, 1, 0, 1, 1, 0);
    drain();

    // R8 / R9: stall codes and refused dispatch
    disp_valid = 1; disp_tag = 4'd15; disp_opnd = 1; disp_mem = 1;
    disp_ld = 1; lq_full = 1; sq_full = 1; grp = 1;
    @(negedge clk); chk(stall == 3'd1, "R8 load full", int'(stall), 1);
    step(); disp_ld = 0; disp_st = 1;
    @(negedge clk); chk(stall == 3'd2, "R8 store full", int'(stall), 2);
    step(); disp_st = 0;
    @(negedge clk); chk(stall == 3'd4, "R8 group stall", int'(stall), 4);
    step(); grp = 0; disp_valid = 0; lq_full = 0; sq_full = 0;
    @(negedge clk); chk(stall == 3'd0, "R8 available", int'(stall), 0);
    repeat (4) step();

    // R11 / R9: fill all entries, refused ninth, then reuse
    for (int t = 0; t < 8; t++) disp(t, 13, 1, 0, 0, 1, 0);
    disp_valid = 1; disp_tag = 4'd15; disp_opnd = 1; disp_mem = 1;
    @(negedge clk); chk(stall == 3'd3, "R11 full", int'(stall), 3);
    step(); disp_valid = 0;
    @(negedge clk); chk(iss_v == 0, "R9 refused not issued", int'(iss_v), 0);
    step();
    for (int t = 0; t < 8; t++) begin exp_iss(t, "R11 full drain order"); exp_wb(t, "R7 wb"); end
    opwake(13);
    drain();
    @(negedge clk); chk(stall == 3'd0, "R11 freed", int'(stall), 0);
    step();
    exp_iss(5, "R11 reuse"); exp_wb(5, "R11 reuse wb");
    disp(5, 0, 1, 0, 1, 1, 0);
    drain();

    chk(iq.size() == 0, "R6 issue queue empty", iq.size(), 0);
    chk(wq.size() == 0, "R7 wb queue empty", wq.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule